// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry-Out

This block shapes the second operand of a 32-bit data-processing datapath. It takes an operand, a two-bit shift kind, an amount and the current carry flag. It returns the shifted operand and the carry bit that the shift produces. A mode select chooses where the amount comes from. In immediate mode only a five-bit field is used. In register mode the amount is the low byte of a register, so it runs from 0 to 255.

Zero and oversized amounts have dedicated meanings. In immediate mode a zero amount is reinterpreted by shift kind: a full 32-bit logical or arithmetic right shift, or a one-bit rotate through the carry flag. In register mode a zero amount leaves the operand and the carry untouched. Amounts of 32 and above saturate, each shift kind following its own result and carry rule.

The outputs are registered, with one cycle of latency, so the shifter can sit at a pipeline boundary in front of the ALU.

Top module: `operand_shifter`

## Requirements
- R1: Result and carry-out appear on the outputs one clock after the inputs are presented. While reset is low, both outputs are zero.
- R2: Shift kind encoding is 00 = left logical, 01 = right logical, 10 = right arithmetic, 11 = rotate right. For an immediate amount n from 1 to 31, the result is the ordinary shift and the carry is the last bit shifted out: operand bit 32−n for left logical, and bit n−1 for the other three kinds.
- R3: An immediate left logical shift by zero passes the operand through, and the carry-out equals the incoming carry.
- R4: An immediate right logical shift by zero acts as a 32-bit shift: the result is zero and the carry-out is operand bit 31.
- R5: An immediate right arithmetic shift by zero fills every result bit with operand bit 31, and the carry-out is operand bit 31.
- R6: An immediate rotate by zero gives the incoming carry in result bit 31 and operand bits 31..1 below it, with operand bit 0 as the carry-out.
- R7: In register mode the amount is the full 8-bit input. An amount of zero passes the operand through with carry-out equal to the incoming carry, for every shift kind.
- R8: A register-mode left or right logical shift by 32 or more gives a zero result. The carry-out is operand bit 0 (left) or bit 31 (right) at exactly 32, and 0 above 32.
- R9: A register-mode right arithmetic shift by 32 or more fills the result with operand bit 31 and gives bit 31 as the carry-out.
- R10: A register-mode rotate uses only amount bits 4..0. When those bits are zero and the full amount is not, the operand passes through and the carry-out is operand bit 31.
- R11: In immediate mode, amount bits 7..5 have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| operand_i | input | 32 | Operand to be shifted |
| shift_kind_i | input | 2 | Shift kind, encoded as in R2 |
| use_reg_i | input | 1 | 1 = register-mode amount, 0 = immediate amount |
| amount_i | input | 8 | Shift amount |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted operand, registered |
| carry_o | output | 1 | Shifter carry-out, registered |

## Verification
The assertions compare each output with the inputs of the previous cycle. They therefore assume the inputs are known and held for one full clock before the edge that captures them. They are also not armed until one clock after reset has been released. The bench changes inputs only on the falling edge and samples a time step after the rising edge, so every capture sees a settled, fully defined input set. The stimulus stays inside the amount ranges the block defines: immediate amounts come with random upper bits, and register amounts cover the full byte.

// File: rtl/shifter_pkg.sv
package shifter_pkg;

    typedef enum logic [1:0] {
        SK_LSL = 2'd0,
        SK_LSR = 2'd1,
        SK_ASR = 2'd2,
        SK_ROR = 2'd3
    } shift_kind_e;

    // How the top stage forms its result and carry
    typedef enum logic [2:0] {
        SC_PASS     = 3'd0,  // operand, incoming carry
        SC_NORM     = 3'd1,  // ordinary shift by n
        SC_ZERO_LO  = 3'd2,  // zero, carry = bit 0
        SC_ZERO_HI  = 3'd3,  // zero, carry = top bit
        SC_ZERO     = 3'd4,  // zero, carry = 0
        SC_FILL     = 3'd5,  // sign fill, carry = top bit
        SC_RRX      = 3'd6,  // rotate through carry by one
        SC_ROT_FULL = 3'd7   // full-width rotate, carry = top bit
    } shift_class_e;

endpackage

// File: rtl/shift_amount_decode.sv
module shift_amount_decode
    import shifter_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int AMT_W = 8,
    localparam int SH_W = $clog2(WIDTH)
) (
    input  shift_kind_e           kind_i,
    input  logic                  use_reg_i,
    input  logic [AMT_W-1:0]      amount_i,
    output shift_class_e          class_o,
    output logic [SH_W-1:0]       n_o
);

    logic [SH_W-1:0] low_bits;
    logic            amt_nonzero;
    logic            amt_exact;
    logic            amt_big;

    always_comb begin
        low_bits    = amount_i[SH_W-1:0];
        amt_nonzero = (amount_i != '0);
        amt_exact   = (amount_i == AMT_W'(WIDTH));
        amt_big     = (amount_i >= AMT_W'(WIDTH));
        n_o         = low_bits;
        class_o     = SC_PASS;

        if (!use_reg_i) begin
            unique case (kind_i)
                SK_LSL: class_o = (low_bits == '0) ? SC_PASS    : SC_NORM;
                SK_LSR: class_o = (low_bits == '0) ? SC_ZERO_HI : SC_NORM;
                SK_ASR: class_o = (low_bits == '0) ? SC_FILL    : SC_NORM;
                SK_ROR: class_o = (low_bits == '0) ? SC_RRX     : SC_NORM;
                default: class_o = SC_PASS;
            endcase
        end else if (!amt_nonzero) begin
            class_o = SC_PASS;
        end else begin
            unique case (kind_i)
                SK_LSL: class_o = amt_exact ? SC_ZERO_LO :
                                  (amt_big ? SC_ZERO : SC_NORM);
                SK_LSR: class_o = amt_exact ? SC_ZERO_HI :
                                  (amt_big ? SC_ZERO : SC_NORM);
                SK_ASR: class_o = amt_big ? SC_FILL : SC_NORM;
                SK_ROR: class_o = (low_bits == '0) ? SC_ROT_FULL : SC_NORM;
                default: class_o = SC_PASS;
            endcase
        end
    end

endmodule

// File: rtl/rotate_right_core.sv
module rotate_right_core #(
    parameter int WIDTH = 32,
    localparam int SH_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] data_i,
    input  logic [SH_W-1:0]  dist_i,
    output logic [WIDTH-1:0] data_o
);

    logic [WIDTH-1:0] stage [SH_W+1];

    assign stage[0] = data_i;

    for (genvar s = 0; s < SH_W; s++) begin : g_stage
        localparam int STEP = 1 << s;
        assign stage[s+1] = dist_i[s]
            ? {stage[s][STEP-1:0], stage[s][WIDTH-1:STEP]}
            : stage[s];
    end

    assign data_o = stage[SH_W];

    // a rotate by zero leaves the word untouched
    always_comb begin
        if (dist_i == '0) begin
            p_rot_zero_r2: assert (data_o == data_i || $isunknown(data_i));
        end
    end

endmodule

// File: rtl/operand_shifter.sv
module operand_shifter
    import shifter_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int AMT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [31:0]      operand_i,
    input  logic [1:0]       shift_kind_i,
    input  logic             use_reg_i,
    input  logic [7:0]       amount_i,
    input  logic             carry_i,
    output logic [31:0]      result_o,
    output logic             carry_o
);

    localparam int SH_W = $clog2(WIDTH);

    typedef struct packed {
        logic [WIDTH-1:0] result;
        logic             carry;
    } shift_state_t;

    shift_state_t    state_d, state_q;
    shift_kind_e     kind;
    shift_class_e    cls;
    logic [SH_W-1:0] n;
    logic [SH_W-1:0] rot_dist;
    logic [WIDTH-1:0] rotated;

    assign kind = shift_kind_e'(shift_kind_i);

    shift_amount_decode #(
        .WIDTH (WIDTH),
        .AMT_W (AMT_W)
    ) u_decode (
        .kind_i    (kind),
        .use_reg_i (use_reg_i),
        .amount_i  (amount_i),
        .class_o   (cls),
        .n_o       (n)
    );

    // a left shift by n is a right rotate by WIDTH-n, then masked
    assign rot_dist = (kind == SK_LSL) ? (~n + 1'b1) : n;

    rotate_right_core #(
        .WIDTH (WIDTH)
    ) u_rotate (
        .data_i (operand_i),
        .dist_i (rot_dist),
        .data_o (rotated)
    );

    always_comb begin
        state_d = state_q;
        unique case (cls)
            SC_PASS: begin
                state_d.result = operand_i;
                state_d.carry  = carry_i;
            end
            SC_NORM: begin
                for (int i = 0; i < WIDTH; i++) begin
                    unique case (kind)
                        SK_LSL: state_d.result[i] = (i >= int'(n)) ? rotated[i] : 1'b0;
                        SK_LSR: state_d.result[i] = (i < WIDTH - int'(n)) ? rotated[i] : 1'b0;
                        SK_ASR: state_d.result[i] = (i < WIDTH - int'(n)) ? rotated[i]
                                                                         : operand_i[WIDTH-1];
                        default: state_d.result[i] = rotated[i];
                    endcase
                end
                if (kind == SK_LSL) begin
                    state_d.carry = operand_i[rot_dist];
                end else begin
                    state_d.carry = operand_i[n - 1'b1];
                end
            end
            SC_ZERO_LO: begin
                state_d.result = '0;
                state_d.carry  = operand_i[0];
            end
            SC_ZERO_HI: begin
                state_d.result = '0;
                state_d.carry  = operand_i[WIDTH-1];
            end
            SC_ZERO: begin
                state_d.result = '0;
                state_d.carry  = 1'b0;
            end
            SC_FILL: begin
                state_d.result = {WIDTH{operand_i[WIDTH-1]}};
                state_d.carry  = operand_i[WIDTH-1];
            end
            SC_RRX: begin
                state_d.result = {carry_i, operand_i[WIDTH-1:1]};
                state_d.carry  = operand_i[0];
            end
            default: begin
                state_d.result = operand_i;
                state_d.carry  = operand_i[WIDTH-1];
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result_o = state_q.result;
    assign carry_o  = state_q.carry;

    // ---------------- assertions ----------------
    logic armed_q;
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (result_o == '0 && carry_o == 1'b0));

    p_imm_lsl_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(!use_reg_i && shift_kind_i == 2'd0 && amount_i[4:0] == 5'd0))
        |-> (result_o == $past(operand_i) && carry_o == $past(carry_i)));

    p_imm_lsr_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(!use_reg_i && shift_kind_i == 2'd1 && amount_i[4:0] == 5'd0))
        |-> (result_o == '0 && carry_o == $past(operand_i[31])));

    p_imm_rrx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(!use_reg_i && shift_kind_i == 2'd3 && amount_i[4:0] == 5'd0))
        |-> (result_o == {$past(carry_i), $past(operand_i[31:1])}
             && carry_o == $past(operand_i[0])));

    p_reg_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(use_reg_i && amount_i == 8'd0))
        |-> (result_o == $past(operand_i) && carry_o == $past(carry_i)));

    p_reg_asr_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(use_reg_i && shift_kind_i == 2'd2 && amount_i >= 8'd32))
        |-> (result_o == {32{$past(operand_i[31])}} && carry_o == $past(operand_i[31])));

    p_reg_logic_over_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(use_reg_i && !shift_kind_i[1] && amount_i > 8'd32))
        |-> (result_o == '0 && carry_o == 1'b0));

endmodule

// File: tb/operand_shifter_test.sv
module operand_shifter_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] operand_i;
    logic [1:0]  shift_kind_i;
    logic        use_reg_i;
    logic [7:0]  amount_i;
    logic        carry_i;
    logic [31:0] result_o;
    logic        carry_o;

    int tests_run = 0;
    int tests_failed = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    operand_shifter uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .operand_i    (operand_i),
        .shift_kind_i (shift_kind_i),
        .use_reg_i    (use_reg_i),
        .amount_i     (amount_i),
        .carry_i      (carry_i),
        .result_o     (result_o),
        .carry_o      (carry_o)
    );

    // {operand, kind, reg, amount, cin, exp_result, exp_carry}
    localparam int NVEC = 12;
    localparam logic [76:0] VECS [NVEC] = '{
        {32'h8000_0001, 2'd0, 1'b0, 8'd1,  1'b0, 32'h0000_0002, 1'b1}, // R2
        {32'h8000_0001, 2'd1, 1'b0, 8'd1,  1'b0, 32'h4000_0000, 1'b1}, // R2
        {32'h8000_0000, 2'd2, 1'b0, 8'd4,  1'b0, 32'hF800_0000, 1'b0}, // R2
        {32'h0000_0011, 2'd3, 1'b0, 8'd4,  1'b1, 32'h1000_0001, 1'b0}, // R2
        {32'h0000_0003, 2'd3, 1'b0, 8'd0,  1'b1, 32'h8000_0001, 1'b1}, // R6
        {32'h1234_5678, 2'd1, 1'b0, 8'd0,  1'b1, 32'h0000_0000, 1'b0}, // R4
        {32'hF000_0000, 2'd2, 1'b0, 8'd0,  1'b0, 32'hFFFF_FFFF, 1'b1}, // R5
        {32'hDEAD_BEEF, 2'd0, 1'b0, 8'd0,  1'b1, 32'hDEAD_BEEF, 1'b1}, // R3
        {32'h0000_0001, 2'd0, 1'b1, 8'd32, 1'b0, 32'h0000_0000, 1'b1}, // R8
        {32'hFFFF_FFFF, 2'd1, 1'b1, 8'd33, 1'b1, 32'h0000_0000, 1'b0}, // R8
        {32'h8000_0000, 2'd3, 1'b1, 8'd64, 1'b0, 32'h8000_0000, 1'b1}, // R10
        {32'h0000_00F0, 2'd3, 1'b1, 8'd36, 1'b1, 32'h0000_000F, 1'b0}  // R10
    };

    // behavioural model written from the requirements
    function automatic logic [32:0] model(input logic [31:0] op, input logic [1:0] k,
                                          input logic r, input logic [7:0] a,
                                          input logic cin);
        logic [31:0] res;
        logic        c;
        int          n;
        if (!r) begin
            n = int'(a[4:0]);
            if (n == 0) begin
                case (k)
                    2'd0: begin res = op;              c = cin;    end
                    2'd1: begin res = '0;              c = op[31]; end
                    2'd2: begin res = {32{op[31]}};    c = op[31]; end
                    default: begin res = {cin, op[31:1]}; c = op[0]; end
                endcase
            end else begin
                case (k)
                    2'd0: begin res = op << n; c = op[32-n]; end
                    2'd1: begin res = op >> n; c = op[n-1];  end
                    2'd2: begin res = $unsigned($signed(op) >>> n); c = op[n-1]; end
                    default: begin res = (op >> n) | (op << (32 - n)); c = op[n-1]; end
                endcase
            end
        end else begin
            n = int'(a);
            if (n == 0) begin
                res = op; c = cin;
            end else begin
                case (k)
                    2'd0: if (n < 32) begin res = op << n; c = op[32-n]; end
                          else begin res = '0; c = (n == 32) ? op[0] : 1'b0; end
                    2'd1: if (n < 32) begin res = op >> n; c = op[n-1]; end
                          else begin res = '0; c = (n == 32) ? op[31] : 1'b0; end
                    2'd2: if (n < 32) begin res = $unsigned($signed(op) >>> n); c = op[n-1]; end
                          else begin res = {32{op[31]}}; c = op[31]; end
                    default: begin
                        n = n % 32;
                        if (n == 0) begin res = op; c = op[31]; end
                        else begin res = (op >> n) | (op << (32 - n)); c = op[n-1]; end
                    end
                endcase
            end
        end
        return {res, c};
    endfunction

    task automatic apply_check(input logic [31:0] op, input logic [1:0] k, input logic r,
                               input logic [7:0] a, input logic cin,
                               input logic [31:0] exp_res, input logic exp_c,
                               input string tag);
        @(negedge clk);
        operand_i = op; shift_kind_i = k; use_reg_i = r; amount_i = a; carry_i = cin;
        @(posedge clk);
        #1;
        tests_run++;
        if (result_o !== exp_res || carry_o !== exp_c) begin
            tests_failed++;
            $display("FAIL %s: op=%h kind=%0d reg=%0d amt=%0d cin=%0d got %h/%0d expected %h/%0d",
                     tag, op, k, r, a, cin, result_o, carry_o, exp_res, exp_c);
        end
    endtask

    function automatic string tag_for(input logic [1:0] k, input logic r, input logic [7:0] a);
        if (!r) begin
            if (a[4:0] != 0) return "R2";
            case (k)
                2'd0: return "R3";
                2'd1: return "R4";
                2'd2: return "R5";
                default: return "R6";
            endcase
        end
        if (a == 0) return "R7";
        if (a < 32 && k != 2'd3) return "R7";
        case (k)
            2'd2: return "R9";
            2'd3: return "R10";
            default: return "R8";
        endcase
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            tests_failed++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end

    initial begin
        logic [32:0] m;
        logic [31:0] rop;
        rst_n = 1'b0;
        operand_i = 32'hFFFF_FFFF; shift_kind_i = 2'd0; use_reg_i = 1'b0;
        amount_i = 8'd0; carry_i = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        tests_run++;
        if (result_o !== 32'h0 || carry_o !== 1'b0) begin  // R1 reset state
            tests_failed++;
            $display("FAIL R1: got %h/%0d expected 00000000/0", result_o, carry_o);
        end
        @(negedge clk);
        rst_n = 1'b1;

        for (int v = 0; v < NVEC; v++) begin
            apply_check(VECS[v][76:45], VECS[v][44:43], VECS[v][42], VECS[v][41:34],
                        VECS[v][33], VECS[v][32:1], VECS[v][0], "R2 table");
        end

        // sweep kinds, modes, boundary amounts, both carries, random operands
        for (int k = 0; k < 4; k++) begin
            for (int r = 0; r < 2; r++) begin
                for (int ai = 0; ai < 6; ai++) begin
                    for (int c = 0; c < 2; c++) begin
                        for (int rep = 0; rep < 4; rep++) begin
                            logic [7:0] a;
                            case (ai)
                                0: a = 8'd0;   1: a = 8'd1;  2: a = 8'd31;
                                3: a = 8'd32;  4: a = 8'd33; default: a = 8'd255;
                            endcase
                            rop = $urandom;
                            m = model(rop, 2'(k), 1'(r), a, 1'(c));
                            apply_check(rop, 2'(k), 1'(r), a, 1'(c), m[32:1], m[0],
                                        tag_for(2'(k), 1'(r), a));
                        end
                    end
                end
            end
        end

        // R11: upper amount bits ignored in immediate mode
        for (int k = 0; k < 4; k++) begin
            for (int rep = 0; rep < 8; rep++) begin
                logic [7:0] a;
                a = 8'($urandom);
                rop = $urandom;
                m = model(rop, 2'(k), 1'b0, {3'b000, a[4:0]}, 1'(rep & 1));
                apply_check(rop, 2'(k), 1'b0, a, 1'(rep & 1), m[32:1], m[0], "R11");
            end
        end

        // R7: full register byte used, random amounts
        for (int rep = 0; rep < 64; rep++) begin
            logic [7:0] a;
            logic [1:0] k;
            a = 8'($urandom);
            k = 2'($urandom);
            rop = $urandom;
            m = model(rop, k, 1'b1, a, 1'(rep & 1));
            apply_check(rop, k, 1'b1, a, 1'(rep & 1), m[32:1], m[0], "R7");
        end

        // R1: reset clears a loaded state
        apply_check(32'hFFFF_FFFF, 2'd0, 1'b0, 8'd0, 1'b1, 32'hFFFF_FFFF, 1'b1, "R1");
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        tests_run++;
        if (result_o !== 32'h0 || carry_o !== 1'b0) begin
            tests_failed++;
            $display("FAIL R1: got %h/%0d expected 00000000/0", result_o, carry_o);
        end

        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule